// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block keeps recently used virtual-to-physical page translations so that most address lookups avoid a page-table walk. It holds 256 translations in two ways of 128 sets. The low bits of the virtual page number pick a set, and both ways of that set are compared at once against the rest of the page number and the current process identifier. A lookup returns one cycle later with a hit flag, the physical page number and a permission-fault flag. A write to a read-only page is reported as a fault and not as a hit.

After a miss, the surrounding logic walks the page tables and writes the full translation through the refill port. The refill first reuses a way that already holds the same page for the same process. If there is no such way it takes a free way. Only when both ways are occupied does a free-running LFSR pick the victim. A flush input clears every entry in one cycle, for use on a context switch. A targeted invalidate input removes one virtual page from the buffer, for every process, after a mapping has changed.

Top module: `tlb2way_top`

## Requirements
- R1: While reset is low and on the first cycle after it, no entry is valid, `rspValid`, `rspHit` and `rspFault` are 0, and `rspPpn` is 0.
- R2: A lookup sampled at a rising edge with `lkValid`=1 produces `rspValid`=1 after that same edge. `rspValid`=0 otherwise. Whenever `rspValid`=0, `rspHit`, `rspFault` and `rspPpn` are all 0.
- R3: The set index is `vpn[6:0]` and the stored tag is `vpn[19:7]`. A lookup hits when one way of the indexed set is valid, its tag equals the looked-up tag, and its stored process identifier equals `lkPid`. A hit returns that entry's physical page number. A miss returns 0.
- R4: An entry written for one process identifier never hits for a lookup that carries a different identifier. Entries from different processes coexist in the same set.
- R5: A refill writes tag, process identifier, physical page and the writable bit into the indexed set. It uses, in priority order: a way already valid with the same tag and process identifier, then way 0 if it is invalid, then way 1 if it is invalid, and otherwise the way given by bit 0 of the LFSR.
- R6: The LFSR is 8 bits wide and resets to 0xA5. It advances on every clock edge out of reset to `{l[6:0], l[7]^l[5]^l[4]^l[3]}`.
- R7: A write lookup (`lkWrite`=1) that matches an entry with writable bit 0 gives `rspFault`=1, `rspHit`=0 and `rspPpn`=0. A read lookup of the same entry hits.
- R8: `flushAll` invalidates every entry in one cycle. It overrides a refill and an invalidate presented in the same cycle.
- R9: An invalidate clears every valid entry of the set indexed by `invVpn[6:0]` whose tag equals `invVpn[19:7]`, whatever its process identifier. Other entries are untouched. If a refill targets the same slot in the same cycle, the refill wins.
- R10: A lookup sees the contents as they were before any refill, invalidate or flush applied at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | 20 | Lookup virtual page number |
| lkPid | input | 8 | Lookup process identifier |
| lkWrite | input | 1 | Lookup is a write access |
| rspValid | output | 1 | Lookup result present |
| rspHit | output | 1 | Usable translation found |
| rspPpn | output | 20 | Physical page number on hit, else 0 |
| rspFault | output | 1 | Write to a read-only page |
| fillValid | input | 1 | Refill request |
| fillVpn | input | 20 | Refill virtual page number |
| fillPid | input | 8 | Refill process identifier |
| fillPpn | input | 20 | Refill physical page number |
| fillWritable | input | 1 | Refill page writable |
| flushAll | input | 1 | Invalidate all entries |
| invValid | input | 1 | Single-page invalidate request |
| invVpn | input | 20 | Page to invalidate |

## Verification
A lookup's hit, fault and physical page appear on the edge after the one that samples the request. Refills, invalidates and flushes change the contents at their own edge, so a lookup that follows one cycle later already sees the change. The reference model in the bench therefore computes each expected response at an edge from the contents held before that edge, and only then applies that edge's updates. The LFSR victim choice is stepped in the model on the same edges as in the design. Outputs are compared at every falling edge, halfway between the edge that set them and the next one.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic doFlush;
    logic doFill;
    logic fillWay;
    logic doInv;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb2_ctrl.sv
module tlb2_ctrl
  import tlb2_pkg::*;
#(
  parameter int unsigned LFSR_W = 8,
  parameter logic [7:0] LFSR_SEED = 8'hA5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fillValid,
  input  logic       flushAll,
  input  logic       invValid,
  input  logic [1:0] fillSetValid,
  input  logic [1:0] fillMatch,
  output tlbStrobe_t strb
);
  logic [LFSR_W-1:0] lfsrQ;
  logic              lfsrFb;
  logic              victimWay;

  // Maximal-length taps 8,6,5,4
  assign lfsrFb = lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= LFSR_SEED;
    else       lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrFb};
  end

  // Same page first, then a free way, then the random pick
  always_comb begin
    if (fillMatch[0])          victimWay = 1'b0;
    else if (fillMatch[1])     victimWay = 1'b1;
    else if (!fillSetValid[0]) victimWay = 1'b0;
    else if (!fillSetValid[1]) victimWay = 1'b1;
    else                       victimWay = lfsrQ[0];
  end

  always_comb begin
    strb.doFlush = flushAll;
    strb.doFill  = fillValid && !flushAll;
    strb.doInv   = invValid && !flushAll;
    strb.fillWay = victimWay;
  end

  // R6: the LFSR never locks up in the all-zero state
  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
  // R5: a refill reuses the way that already holds the same page
  a_r5_reuse_same_page: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillMatch == 2'b10) |-> strb.fillWay);
endmodule

// File: rtl/tlb2_datapath.sv
module tlb2_datapath
  import tlb2_pkg::*;
#(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned PID_W = 8,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strb,
  input  logic             lkValid,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic [PID_W-1:0] lkPid,
  input  logic             lkWrite,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PID_W-1:0] fillPid,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             fillWritable,
  input  logic [VPN_W-1:0] invVpn,
  output logic [1:0]       fillSetValid,
  output logic [1:0]       fillMatch,
  output logic             rspValid,
  output logic             rspHit,
  output logic [PPN_W-1:0] rspPpn,
  output logic             rspFault
);
  localparam int unsigned WAYS  = 2;
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  logic [IDX_W-1:0] lkIdx, fillIdx, invIdx;
  logic [TAG_W-1:0] lkTag, fillTag, invTag;

  assign lkIdx   = lkVpn[IDX_W-1:0];
  assign lkTag   = lkVpn[VPN_W-1:IDX_W];
  assign fillIdx = fillVpn[IDX_W-1:0];
  assign fillTag = fillVpn[VPN_W-1:IDX_W];
  assign invIdx  = invVpn[IDX_W-1:0];
  assign invTag  = invVpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0]             lkMatch;
  logic [WAYS-1:0]             lkRw;
  logic [WAYS-1:0][PPN_W-1:0]  lkPpnW;
  logic [WAYS-1:0]             invHit;

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    logic [SETS-1:0]  validQ;
    logic [SETS-1:0]  rwQ;
    logic [TAG_W-1:0] tagQ [SETS];
    logic [PID_W-1:0] pidQ [SETS];
    logic [PPN_W-1:0] ppnQ [SETS];
    logic             wrThisWay;

    assign wrThisWay = strb.doFill && (strb.fillWay == 1'(w));

    // Later assignment wins: refill beats invalidate on the same slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= '0;
      end else if (strb.doFlush) begin
        validQ <= '0;
      end else begin
        if (strb.doInv && invHit[w]) validQ[invIdx] <= 1'b0;
        if (wrThisWay)               validQ[fillIdx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wrThisWay) begin
        tagQ[fillIdx] <= fillTag;
        pidQ[fillIdx] <= fillPid;
        ppnQ[fillIdx] <= fillPpn;
        rwQ[fillIdx]  <= fillWritable;
      end
    end

    assign lkMatch[w] = validQ[lkIdx] && (tagQ[lkIdx] == lkTag) && (pidQ[lkIdx] == lkPid);
    assign lkRw[w]    = rwQ[lkIdx];
    assign lkPpnW[w]  = ppnQ[lkIdx];
    assign fillSetValid[w] = validQ[fillIdx];
    assign fillMatch[w] = validQ[fillIdx] && (tagQ[fillIdx] == fillTag) && (pidQ[fillIdx] == fillPid);
    assign invHit[w]  = validQ[invIdx] && (tagQ[invIdx] == invTag);
  end

  // Lookup result, registered
  logic             anyMatch, selWay, permBad, hitD, faultD;
  logic [PPN_W-1:0] ppnD;

  always_comb begin
    anyMatch = |lkMatch;
    selWay   = lkMatch[1];
    permBad  = lkWrite && !lkRw[selWay];
    hitD     = lkValid && anyMatch && !permBad;
    faultD   = lkValid && anyMatch && permBad;
    ppnD     = hitD ? lkPpnW[selWay] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspFault <= 1'b0;
      rspPpn   <= '0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= hitD;
      rspFault <= faultD;
      rspPpn   <= ppnD;
    end
  end

  // R2: a response follows every lookup by one cycle
  a_r2_rsp_follows_lookup: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!rspValid && !rspHit && !rspFault));
  // R7: a fault is never also a usable hit
  a_r7_fault_excludes_hit: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (!rspHit && rspPpn == '0));
  // R5: refill priority keeps one copy of a page per process
  a_r5_no_duplicate: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> ($countones(lkMatch) <= 1));
  // R8: a lookup right after a flush cannot hit
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doFlush ##1 lkValid) |=> (!rspHit && !rspFault));
  a_r8_flush_blocks_fill: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFlush |-> (!strb.doFill && !strb.doInv));
endmodule

// File: rtl/tlb2way_top.sv
module tlb2way_top
  import tlb2_pkg::*;
#(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned PID_W = 8,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic [PID_W-1:0] lkPid,
  input  logic             lkWrite,
  output logic             rspValid,
  output logic             rspHit,
  output logic [PPN_W-1:0] rspPpn,
  output logic             rspFault,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PID_W-1:0] fillPid,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             fillWritable,
  input  logic             flushAll,
  input  logic             invValid,
  input  logic [VPN_W-1:0] invVpn
);
  tlbStrobe_t strb;
  logic [1:0] fillSetValid;
  logic [1:0] fillMatch;

  tlb2_ctrl #(.LFSR_W(8), .LFSR_SEED(8'hA5)) uCtrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .flushAll(flushAll),
    .invValid(invValid), .fillSetValid(fillSetValid), .fillMatch(fillMatch),
    .strb(strb)
  );

  tlb2_datapath #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lkValid(lkValid), .lkVpn(lkVpn), .lkPid(lkPid), .lkWrite(lkWrite),
    .fillVpn(fillVpn), .fillPid(fillPid), .fillPpn(fillPpn), .fillWritable(fillWritable),
    .invVpn(invVpn), .fillSetValid(fillSetValid), .fillMatch(fillMatch),
    .rspValid(rspValid), .rspHit(rspHit), .rspPpn(rspPpn), .rspFault(rspFault)
  );
endmodule

// File: tb/tb_tlb2way_top.sv
module tb_tlb2way_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 0, lkWrite = 0, fillValid = 0, fillWritable = 0;
  logic        flushAll = 0, invValid = 0;
  logic [19:0] lkVpn = 0, fillVpn = 0, fillPpn = 0, invVpn = 0;
  logic [7:0]  lkPid = 0, fillPid = 0;
  logic        rspValid, rspHit, rspFault;
  logic [19:0] rspPpn;

  always #10 clk = ~clk;  // 50 MHz

  tlb2way_top dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkPid(lkPid),
    .lkWrite(lkWrite), .rspValid(rspValid), .rspHit(rspHit), .rspPpn(rspPpn),
    .rspFault(rspFault), .fillValid(fillValid), .fillVpn(fillVpn), .fillPid(fillPid),
    .fillPpn(fillPpn), .fillWritable(fillWritable), .flushAll(flushAll),
    .invValid(invValid), .invVpn(invVpn)
  );

  int    nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit    finished = 0;

  // Behavioural reference: a list of resident translations per set and way
  bit          mValid [2][128];
  bit [19:0]   mVpn   [2][128];
  bit [7:0]    mPid   [2][128];
  bit [19:0]   mPpn   [2][128];
  bit          mRw    [2][128];
  bit [7:0]    mLfsr;
  bit          eValid, eHit, eFault;
  bit [19:0]   ePpn;

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < 2; w++) for (int s = 0; s < 128; s++) mValid[w][s] = 0;
      mLfsr = 8'hA5;
      eValid = 0; eHit = 0; eFault = 0; ePpn = 0;
    end else begin
      int s, way;
      bit found, foundRw;
      bit [19:0] foundPpn;
      // lookup against the contents before this edge
      found = 0; foundRw = 0; foundPpn = 0;
      s = int'(lkVpn[6:0]);
      for (int w = 0; w < 2; w++)
        if (mValid[w][s] && mVpn[w][s][19:7] == lkVpn[19:7] && mPid[w][s] == lkPid) begin
          found = 1; foundRw = mRw[w][s]; foundPpn = mPpn[w][s];
        end
      eValid = lkValid;
      eHit   = lkValid && found && !(lkWrite && !foundRw);
      eFault = lkValid && found && lkWrite && !foundRw;
      ePpn   = eHit ? foundPpn : 20'h0;
      // updates
      if (flushAll) begin
        for (int w = 0; w < 2; w++) for (int t = 0; t < 128; t++) mValid[w][t] = 0;
      end else begin
        s = int'(fillVpn[6:0]);
        way = -1;
        for (int w = 1; w >= 0; w--)
          if (mValid[w][s] && mVpn[w][s][19:7] == fillVpn[19:7] && mPid[w][s] == fillPid) way = w;
        if (way < 0) begin
          if (!mValid[0][s]) way = 0;
          else if (!mValid[1][s]) way = 1;
          else way = int'(mLfsr[0]);
        end
        if (invValid) begin
          for (int w = 0; w < 2; w++)
            if (mVpn[w][invVpn[6:0]][19:7] == invVpn[19:7]) mValid[w][invVpn[6:0]] = 0;
        end
        if (fillValid) begin
          mValid[way][s] = 1; mVpn[way][s] = fillVpn; mPid[way][s] = fillPid;
          mPpn[way][s] = fillPpn; mRw[way][s] = fillWritable;
        end
      end
      mLfsr = {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        check("R1", "rspValid in reset", int'(rspValid), 0);
        check("R1", "rspPpn in reset", int'(rspPpn), 0);
      end else begin
        check(curReq, "rspValid", int'(rspValid), int'(eValid));
        check(curReq, "rspHit", int'(rspHit), int'(eHit));
        check(curReq, "rspFault", int'(rspFault), int'(eFault));
        check(curReq, "rspPpn", int'(rspPpn), int'(ePpn));
      end
    end
  end

  task automatic step();
    @(negedge clk);
    lkValid = 0; fillValid = 0; flushAll = 0; invValid = 0; lkWrite = 0;
  endtask
  task automatic lookup(logic [19:0] v, logic [7:0] p, logic wr);
    lkValid = 1; lkVpn = v; lkPid = p; lkWrite = wr;
  endtask
  task automatic fill(logic [19:0] v, logic [7:0] p, logic [19:0] pp, logic rw);
    fillValid = 1; fillVpn = v; fillPid = p; fillPpn = pp; fillWritable = rw;
  endtask

  // Directed expectations independent of the model
  task automatic expectHit(string req, logic [19:0] pp);
    @(posedge clk); #1;
    check(req, "directed hit", int'(rspHit), 1);
    check(req, "directed ppn", int'(rspPpn), int'(pp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1", "rspHit after reset", int'(rspHit), 0);
    rstN = 1;
    lookup(20'h00000, 8'd0, 0); step(); step();

    curReq = "R3";
    fill(20'h00123, 8'd5, 20'hABCDE, 1); step();
    lookup(20'h00123, 8'd5, 0); fork expectHit("R3", 20'hABCDE); join_none step(); step();
    lookup(20'h00124, 8'd5, 0); step(); step();

    curReq = "R4";
    lookup(20'h00123, 8'd6, 0); step();
    fill(20'h00123, 8'd6, 20'h11111, 1); step();
    lookup(20'h00123, 8'd6, 0); step();
    lookup(20'h00123, 8'd5, 0); step(); step();

    curReq = "R5";
    fill(20'h01005, 8'd1, 20'h00A01, 1); step();
    fill(20'h02005, 8'd1, 20'h00A02, 1); step();
    fill(20'h02005, 8'd1, 20'h00A22, 1); step();
    lookup(20'h01005, 8'd1, 0); step();
    lookup(20'h02005, 8'd1, 0); step();

    curReq = "R6";
    for (int i = 0; i < 12; i++) begin
      fill(20'h03005 + 20'(i << 12), 8'd1, 20'h00B00 + 20'(i), 1); step();
      lookup(20'h01005, 8'd1, 0); step();
      lookup(20'h02005, 8'd1, 0); step();
    end

    curReq = "R7";
    fill(20'h00777, 8'd2, 20'h0C0DE, 0); step();
    lookup(20'h00777, 8'd2, 1); step();
    lookup(20'h00777, 8'd2, 0); step(); step();

    curReq = "R9";
    invValid = 1; invVpn = 20'h00123; step();
    lookup(20'h00123, 8'd5, 0); step();
    lookup(20'h00123, 8'd6, 0); step();
    lookup(20'h00777, 8'd2, 0); step();
    fill(20'h00123, 8'd5, 20'h22222, 1); invValid = 1; invVpn = 20'h00123; step();
    lookup(20'h00123, 8'd5, 0); step(); step();

    curReq = "R10";
    lookup(20'h00777, 8'd2, 0); invValid = 1; invVpn = 20'h00777; step();
    lookup(20'h00777, 8'd2, 0); step();
    fill(20'h00456, 8'd3, 20'h33333, 1); lookup(20'h00456, 8'd3, 0); step();
    lookup(20'h00456, 8'd3, 0); step(); step();

    curReq = "R8";
    flushAll = 1; step();
    lookup(20'h00456, 8'd3, 0); step();
    lookup(20'h00123, 8'd5, 0); step();
    fill(20'h00999, 8'd4, 20'h44444, 1); flushAll = 1; step();
    lookup(20'h00999, 8'd4, 0); step(); step();

    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] v;
      v = {16'(($urandom_range(0, 3)) << 3), 4'($urandom_range(0, 3))};
      v = {v[19:7] | 13'h0, v[6:0]};
      if ($urandom_range(0, 2) != 0) lookup(v, 8'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 2) == 0) begin
        fill({13'($urandom_range(0, 5)), 7'($urandom_range(0, 3))}, 8'($urandom_range(0, 1)),
             20'($urandom), 1'($urandom_range(0, 1)));
      end
      if ($urandom_range(0, 9) == 0) begin
        invValid = 1; invVpn = {13'($urandom_range(0, 5)), 7'($urandom_range(0, 3))};
      end
      if ($urandom_range(0, 99) == 0) flushAll = 1;
      if (lkValid) lkVpn = {13'($urandom_range(0, 5)), 7'($urandom_range(0, 3))};
      step();
    end
    step(); step();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL %s watchdog: actual %0d expected %0d", curReq, 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule